// File: doc/BRIEF.md
# Concurrent Self-Checking Parity Monitor

This block runs next to an exclusive-OR parity tree while the tree does its normal work. It holds a circular register of seven stages. Each stage carries the current bit of one of seven code words, and these code words are the rotations of a single maximum-length shift-register sequence. Every tree input line is tied to one of those words. Together, the current register bits therefore spell out one test pattern for the tree inputs.

The monitor does not steal cycles from the tree. On each strobed cycle it compares the live input word with the current test pattern. When the two agree, the observed tree output is compared with the current bit of the output's code word, and the register rotates once so that the next test pattern comes up. After seven such coincidences every exclusive-OR gate in the tree has received a complete functional test, and a one-cycle completion pulse is given. An all-zero input word is treated as one more test whose correct output is 0. Any wrong output sets a sticky error flag.

Top module: `parity_tree_monitor`

## Requirements
- R1: After a synchronous active-low reset, `err_flag` and `sweep_done` are 0 and the register holds the seed word 1011100 (leftmost character is time step 0). Stage j then holds bit step 0 of the seed rotated right by j steps, so the first test pattern is column 0 of the seven words.
- R2: A cycle is a match when `sample_vld` is 1 and every tree line equals the current register bit of the code word it is mapped to. Lines mapped to the same word are checked together, in true form when that bit is 1 and in inverted form when it is 0.
- R3: On a match, if `tree_out` differs from the current register bit of word `OUT_WORD` (default 0), `err_flag` is 1 from the next cycle.
- R4: Each match rotates the register by exactly one step. After n matches since reset, the expected pattern is column n mod 7, in which word j has bit W0[(n-j) mod 7].
- R5: A cycle with `sample_vld` low, or a valid cycle with no match and a non-zero input, changes neither the register, the counter nor `err_flag`, whatever the value of `tree_out`.
- R6: `sweep_done` is 1 for exactly the one cycle after every seventh match.
- R7: Once set, `err_flag` stays 1 until reset.
- R8: A valid all-zero input word with `tree_out` at 1 sets `err_flag` on the next cycle. With `tree_out` at 0 it does not.
- R9: In the default configuration, lines 0 to 4 are mapped to words 2, 3, 5, 6 and 3, and the tree output is mapped to word 0. The mapping is packed as 3-bit indices with line 0 in the least significant field. The exclusive-OR of the mapped words equals word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; reloads the seed |
| sample_vld | input | 1 | Marks a cycle whose tree inputs and output are meaningful |
| tree_in | input | NUM_LINES | Functional inputs of the parity tree |
| tree_out | input | 1 | Observed output of the parity tree |
| err_flag | output | 1 | Sticky fault indication |
| sweep_done | output | 1 | One-cycle pulse after each complete seven-pattern test |

## Verification
Every result is registered, so the flag and the pulse caused by a sample on one rising edge appear one clock later. The bench drives each sample on a falling edge and reads both outputs on the following falling edge. At that point the edge that consumed the sample has passed and the next sample has not yet been applied.

The bench keeps its own pattern index and match counter, computed from the rotated seed. Against this model it sweeps all 32 input words repeatedly, walks a deliberate fault through each of the seven pattern positions, and probes invalid, non-matching and all-zero cycles.

// File: rtl/ptm_pkg.sv
package ptm_pkg;

    // Stage j of the ring holds, at step 0, bit position (len - j) mod len
    // of the seed (position 0 is the seed's most significant bit).
    function automatic logic [63:0] ring_start(input logic [63:0] seed, input int len);
        logic [63:0] r;
        r = '0;
        for (int j = 0; j < len; j++) begin
            r[j] = seed[len - 1 - ((len - j) % len)];
        end
        return r;
    endfunction

    // Select mask of the lines that are mapped to code word g.
    function automatic logic [63:0] group_mask(input logic [255:0] map, input int lines,
                                               input int idx_w, input int g);
        logic [63:0] m;
        m = '0;
        for (int i = 0; i < lines; i++) begin
            int idx;
            idx = 0;
            for (int b = 0; b < idx_w; b++) begin
                idx = idx | (int'(map[i*idx_w + b]) << b);
            end
            m[i] = (idx == g);
        end
        return m;
    endfunction

endpackage

// File: rtl/cw_ring.sv
module cw_ring #(
    parameter int                  SEQ_LEN = 7,
    parameter logic [SEQ_LEN-1:0]  SEED    = 7'b1011100
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               advance,
    output logic [SEQ_LEN-1:0] ring_q
);
    import ptm_pkg::*;

    localparam logic [63:0]        START_WIDE = ring_start(64'(SEED), SEQ_LEN);
    localparam logic [SEQ_LEN-1:0] START      = START_WIDE[SEQ_LEN-1:0];

    typedef struct packed {
        logic [SEQ_LEN-1:0] ring;
    } ring_state_t;

    ring_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (advance) begin
            st_d.ring = {st_q.ring[SEQ_LEN-2:0], st_q.ring[SEQ_LEN-1]};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ring <= START;
        end else begin
            st_q <= st_d;
        end
    end

    assign ring_q = st_q.ring;

    assert_ring_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(ring_q));

    assert_ring_moves_R4: assert property (@(posedge clk) disable iff (!rst_n)
        advance |=> (ring_q != $past(ring_q)));

    assert_ring_weight_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(ring_q) == $countones(SEED));

endmodule

// File: rtl/pattern_match.sv
module pattern_match #(
    parameter int                              NUM_LINES = 5,
    parameter int                              SEQ_LEN   = 7,
    parameter int                              IDX_W     = 3,
    parameter logic [NUM_LINES*IDX_W-1:0]      LINE_MAP  = {3'd3, 3'd6, 3'd5, 3'd3, 3'd2}
) (
    input  logic [NUM_LINES-1:0] lines,
    input  logic [SEQ_LEN-1:0]   ring,
    output logic                 hit
);
    import ptm_pkg::*;

    logic [SEQ_LEN-1:0] grp_ok;

    for (genvar g = 0; g < SEQ_LEN; g++) begin : g_word
        localparam logic [63:0] MASK_WIDE = group_mask(256'(LINE_MAP), NUM_LINES, IDX_W, g);
        localparam logic [NUM_LINES-1:0] MASK = MASK_WIDE[NUM_LINES-1:0];

        logic all_high;
        logic all_low;

        // True-polarity term and inverted term over this word's lines.
        assign all_high  = &(lines  | ~MASK);
        assign all_low   = &(~lines | ~MASK);
        assign grp_ok[g] = ring[g] ? all_high : all_low;
    end

    assign hit = &grp_ok;

endmodule

// File: rtl/shift_tally.sv
module shift_tally #(
    parameter int SEQ_LEN = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    output logic wrap_q
);
    localparam int CNT_W = $clog2(SEQ_LEN);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SEQ_LEN - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             wrap;
    } tally_t;

    tally_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.wrap = 1'b0;
        if (step) begin
            if (st_q.cnt == LAST) begin
                st_d.cnt  = '0;
                st_d.wrap = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wrap_q = st_q.wrap;

    assert_wrap_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_q |=> !wrap_q);

    assert_idle_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> !wrap_q);

endmodule

// File: rtl/parity_tree_monitor.sv
module parity_tree_monitor #(
    parameter int                                     K         = 3,
    parameter int                                     NUM_LINES = 5,
    parameter logic [NUM_LINES*$clog2((1<<K)-1)-1:0]  LINE_MAP  = {3'd3, 3'd6, 3'd5, 3'd3, 3'd2},
    parameter int                                     OUT_WORD  = 0,
    parameter logic [(1<<K)-2:0]                      SEED      = 7'b1011100
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sample_vld,
    input  logic [NUM_LINES-1:0] tree_in,
    input  logic                 tree_out,
    output logic                 err_flag,
    output logic                 sweep_done
);
    localparam int SEQ_LEN = (1 << K) - 1;
    localparam int IDX_W   = $clog2(SEQ_LEN);

    typedef struct packed {
        logic err;
    } mon_state_t;

    logic [SEQ_LEN-1:0] ring;
    logic               pat_hit;
    logic               match;
    logic               zero_word;
    logic               expect_bit;
    mon_state_t         st_d, st_q;

    cw_ring #(
        .SEQ_LEN (SEQ_LEN),
        .SEED    (SEED)
    ) u_ring (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (match),
        .ring_q  (ring)
    );

    pattern_match #(
        .NUM_LINES (NUM_LINES),
        .SEQ_LEN   (SEQ_LEN),
        .IDX_W     (IDX_W),
        .LINE_MAP  (LINE_MAP)
    ) u_match (
        .lines (tree_in),
        .ring  (ring),
        .hit   (pat_hit)
    );

    shift_tally #(
        .SEQ_LEN (SEQ_LEN)
    ) u_tally (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (match),
        .wrap_q (sweep_done)
    );

    assign match      = sample_vld & pat_hit;
    assign zero_word  = sample_vld & (tree_in == '0);
    assign expect_bit = ring[OUT_WORD];

    always_comb begin
        st_d = st_q;
        if (match && (tree_out != expect_bit)) begin
            st_d.err = 1'b1;
        end
        if (zero_word && tree_out) begin
            st_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign err_flag = st_q.err;

    assert_bad_output_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_vld && pat_hit && (tree_out != ring[OUT_WORD])) |=> err_flag);

    assert_zero_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_vld && (tree_in == '0) && tree_out) |=> err_flag);

    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);

    assert_invalid_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!sample_vld && !err_flag) |=> !err_flag);

endmodule

// File: tb/parity_tree_monitor_tb.sv
module parity_tree_monitor_tb;

    localparam int       CLK_PERIOD = 10;
    localparam int       NL         = 5;
    localparam int       SL         = 7;
    localparam bit [6:0] SEED_W     = 7'b1011100;
    localparam int       MAP [NL]   = '{2, 3, 5, 6, 3};

    logic          clk = 1'b0;
    logic          rst_n;
    logic          sample_vld;
    logic [NL-1:0] tree_in;
    logic          tree_out;
    logic          err_flag;
    logic          sweep_done;

    int checks = 0;
    int errors = 0;

    int m_step;
    int m_cnt;
    bit m_err;
    bit m_done;

    always #(CLK_PERIOD/2) clk = ~clk;

    parity_tree_monitor u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_vld (sample_vld),
        .tree_in    (tree_in),
        .tree_out   (tree_out),
        .err_flag   (err_flag),
        .sweep_done (sweep_done)
    );

    function automatic bit word_bit(int j, int t);
        int p;
        p = (((t - j) % SL) + SL) % SL;
        return SEED_W[SL - 1 - p];
    endfunction

    function automatic logic [NL-1:0] pattern_at(int t);
        logic [NL-1:0] v;
        for (int i = 0; i < NL; i++) v[i] = word_bit(MAP[i], t);
        return v;
    endfunction

    task automatic check(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b (step %0d)", req, act, exp, m_step);
        end
    endtask

    // Called at a falling edge: drive, let one rising edge pass, return at next falling edge.
    task automatic apply(logic vld, logic [NL-1:0] v, logic tout);
        bit hit;
        sample_vld = vld;
        tree_in    = v;
        tree_out   = tout;
        hit    = vld && (v == pattern_at(m_step));
        m_done = hit && (m_cnt == SL - 1);
        if (hit && (tout != word_bit(0, m_step))) m_err = 1'b1;
        if (vld && (v == '0) && tout) m_err = 1'b1;
        if (hit) begin
            m_step = (m_step + 1) % SL;
            m_cnt  = (m_cnt + 1) % SL;
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n      = 1'b0;
        sample_vld = 1'b0;
        tree_in    = '0;
        tree_out   = 1'b0;
        repeat (2) @(negedge clk);
        rst_n  = 1'b1;
        m_step = 0;
        m_cnt  = 0;
        m_err  = 1'b0;
        m_done = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        sample_vld = 1'b0;
        tree_in = '0;
        tree_out = 1'b0;
        @(negedge clk);
        do_reset();
        check("R1 err after reset", err_flag, 1'b0);
        check("R1 done after reset", sweep_done, 1'b0);

        // R9: a correct tree (parity of inputs) yields word 0 on every pattern
        for (int t = 0; t < SL; t++) begin
            check("R9 parity equals W0", ^pattern_at(t), word_bit(0, t));
        end

        // R2 R4 R6: repeated sweeps over all input words with a correct tree
        for (int pass = 0; pass < 6; pass++) begin
            for (int v = 0; v < (1 << NL); v++) begin
                apply(1'b1, NL'(v), ^NL'(v));
                check("R4 R6 done pulse", sweep_done, m_done);
                check("R2 no false error", err_flag, m_err);
            end
        end

        // R5: invalid cycles with a wrong output touch nothing
        for (int v = 0; v < (1 << NL); v++) begin
            apply(1'b0, NL'(v), ~^NL'(v));
            check("R5 invalid err", err_flag, 1'b0);
            check("R5 invalid done", sweep_done, 1'b0);
        end
        // R5: valid non-matching non-zero words with a wrong output
        for (int v = 1; v < (1 << NL); v++) begin
            if (NL'(v) != pattern_at(m_step)) begin
                apply(1'b1, NL'(v), ~^NL'(v));
                check("R5 non-match err", err_flag, 1'b0);
            end
        end
        // state unchanged: the model's pattern still advances the monitor in step
        for (int s = 0; s < SL; s++) begin
            apply(1'b1, pattern_at(m_step), word_bit(0, m_step));
            check("R5 R6 alignment done", sweep_done, m_done);
        end
        check("R5 R6 wrap seen", m_done, 1'b1);

        // R8: all-zero word with correct output, then with wrong output
        apply(1'b1, '0, 1'b0);
        check("R8 zero ok", err_flag, 1'b0);
        apply(1'b1, '0, 1'b1);
        check("R8 zero fault", err_flag, 1'b1);
        // R7: sticky through correct traffic and idle cycles
        for (int c = 0; c < 20; c++) begin
            apply(c[0], pattern_at(m_step), word_bit(0, m_step));
            check("R7 sticky", err_flag, 1'b1);
        end
        do_reset();
        check("R1 R7 cleared by reset", err_flag, 1'b0);

        // R1 R3 R4: a fault placed at each pattern position is caught there
        for (int t = 0; t < SL; t++) begin
            do_reset();
            for (int s = 0; s < t; s++) begin
                apply(1'b1, pattern_at(s), word_bit(0, s));
                check("R4 good step", err_flag, 1'b0);
            end
            apply(1'b1, pattern_at(t), ~word_bit(0, t));
            check("R3 fault caught", err_flag, 1'b1);
        end

        // R1: the seed pattern is the first one accepted
        do_reset();
        apply(1'b1, pattern_at(1), ~word_bit(0, 1));
        check("R1 seed not column 1", err_flag, 1'b0);
        apply(1'b1, pattern_at(0), ~word_bit(0, 0));
        check("R1 seed column 0", err_flag, 1'b1);

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule